// File: doc/BRIEF.md
# Dual-port Wishbone master with firmware byte-lane steering

This block turns decoded host-bus requests into single Wishbone classic cycles. Each request targets one of two independent master ports. The I/O port carries 8-bit data at a 16-bit address. The firmware-memory port carries a 32-bit word. On that port the block turns 1-, 2- and 4-byte transfers into a word address, byte selects and lane-shifted data. For reads it right-aligns the addressed bytes from the returned word.

A requester presents a request with `req_valid` and a target flag. The request is taken on a clock edge where the targeted port reports ready. The port then holds its cycle open until the slave acknowledges. One cycle later it pulses a done strobe and presents the read data. Each port has at most one cycle in flight, and the two ports work independently of each other. Reset is asserted asynchronously and active-low, and its release is synchronised inside the block.

Top module: `fwio_wb_master`

## Requirements
- R1: While reset is held and after it is released, with no request given, both `*_wb_cyc`/`*_wb_stb` and both done strobes are 0, and both ready outputs are 1.
- R2: An I/O request (`req_fw`=0) taken at an edge raises `io_wb_cyc` and `io_wb_stb` after that edge, with `io_wb_adr` = `req_addr[15:0]`, `io_wb_we` = `req_write` and `io_wb_dat_w` = `req_wdata[7:0]`.
- R3: On either port, cyc and stb, together with the address, we, select and write data, stay unchanged until ack is sampled high. After that edge, cyc and stb are 0.
- R4: At the edge where ack is sampled high, the port's done strobe goes to 1 for exactly one cycle, and its read data takes the value of `*_wb_dat_r` sampled at that edge.
- R5: From acceptance until its done cycle, a port's ready output is 0. A request aimed at a busy port is ignored: the cycle in progress keeps its address, and no second cycle follows.
- R6: A firmware request (`req_fw`=1) drives `fw_wb_adr` = `req_addr >> 2` and `fw_wb_we` = `req_write`.
- R7: For `req_size`=2'b00 (one byte), `fw_wb_sel` = 4'b0001 << `req_addr[1:0]`. `fw_wb_dat_w` holds `req_wdata[7:0]` at bit 8*`req_addr[1:0]`, and all other lanes are 0.
- R8: For `req_size`=2'b01 (two bytes), `fw_wb_sel` = 4'b0011 << (`req_addr` & 2). `fw_wb_dat_w` holds `req_wdata[15:0]` at bit 8*(`req_addr` & 2), and all other lanes are 0. `req_addr[0]` is ignored.
- R9: For `req_size`=2'b10 or 2'b11 (four bytes), `fw_wb_sel` = 4'b1111 and `fw_wb_dat_w` = `req_wdata`. `req_addr[1:0]` is ignored.
- R10: On a firmware read, `fw_rdata` = (`fw_wb_dat_r` >> lane offset), masked to the access size. The lane offset is the one from R7 to R9, and the bits above the size are 0.
- R11: An I/O cycle and a firmware cycle may be open at the same time, and each completes on its own ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_fw | input | 1 | 1 = firmware port, 0 = I/O port |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Firmware size: 00 byte, 01 halfword, 1x word |
| req_addr | input | 28 | Byte address (I/O uses bits 15:0) |
| req_wdata | input | 32 | Write data, right-aligned |
| io_ready | output | 1 | I/O port can take a request |
| fw_ready | output | 1 | Firmware port can take a request |
| io_done | output | 1 | I/O cycle finished (one-cycle pulse) |
| io_rdata | output | 8 | I/O read data, valid with io_done |
| fw_done | output | 1 | Firmware cycle finished (one-cycle pulse) |
| fw_rdata | output | 32 | Right-aligned firmware read data, valid with fw_done |
| io_wb_cyc | output | 1 | I/O port cycle |
| io_wb_stb | output | 1 | I/O port strobe |
| io_wb_we | output | 1 | I/O port write enable |
| io_wb_adr | output | 16 | I/O port address |
| io_wb_dat_w | output | 8 | I/O port write data |
| io_wb_dat_r | input | 8 | I/O port read data |
| io_wb_ack | input | 1 | I/O port acknowledge |
| fw_wb_cyc | output | 1 | Firmware port cycle |
| fw_wb_stb | output | 1 | Firmware port strobe |
| fw_wb_we | output | 1 | Firmware port write enable |
| fw_wb_adr | output | 26 | Firmware word address |
| fw_wb_sel | output | 4 | Firmware byte selects |
| fw_wb_dat_w | output | 32 | Firmware write data on lanes |
| fw_wb_dat_r | input | 32 | Firmware read data |
| fw_wb_ack | input | 1 | Firmware port acknowledge |

## Verification
Byte transfers are tried at all four lane offsets, and halfword transfers at offsets 0 and 2. A halfword is also tried with address bit 0 set, and a word with both low address bits set. This separates correct lane steering from steering that ignores the size, misuses the low address bits or leaves stale data on unused lanes. Reads use a returned word with distinct bytes, so that a wrong shift or a missing mask gives a visibly different value. I/O traffic covers an acknowledge delayed by several cycles and a request aimed at a busy port. It also covers overlapping I/O and firmware cycles, which show whether the hold, the one-cycle completion and the independence of the two ports are correct.

// File: rtl/fwio_wb_pkg.sv
package fwio_wb_pkg;
  // transfer size encoding on req_size
  typedef enum logic [1:0] {
    XS_BYTE  = 2'b00,
    XS_HALF  = 2'b01,
    XS_WORD  = 2'b10,
    XS_WORD2 = 2'b11
  } xfer_size_e;
endpackage

// File: rtl/fwio_rst_sync.sv
module fwio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/fwio_lane_plan.sv
module fwio_lane_plan
  import fwio_wb_pkg::*;
#(
  parameter int DW = 32
) (
  input  xfer_size_e            size_i,
  input  logic [$clog2(DW/8)-1:0] addr_lo_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [DW/8-1:0]       sel_o,
  output logic [$clog2(DW/8)-1:0] off_o,
  output logic [DW-1:0]         mask_o,
  output logic [DW-1:0]         lanes_o
);
  localparam int LANES = DW / 8;
  localparam int OFF_W = $clog2(LANES);

  logic [OFF_W:0]   nbytes;
  logic [OFF_W-1:0] align_m;

  always_comb begin
    unique case (size_i)
      XS_BYTE: nbytes = (OFF_W+1)'(1);
      XS_HALF: nbytes = (OFF_W+1)'(2);
      default: nbytes = (OFF_W+1)'(4);
    endcase
    // clear the low address bits that lie inside the access
    align_m = ~(nbytes[OFF_W-1:0] - OFF_W'(1));
    off_o   = addr_lo_i & align_m;
  end

  logic [LANES-1:0] sel_base;
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sel_base[g]       = (g < int'(nbytes));
    assign mask_o[g*8 +: 8]  = {8{sel_base[g]}};
  end

  assign sel_o   = sel_base << off_o;
  assign lanes_o = (wdata_i & mask_o) << {off_o, 3'b000};
endmodule

// File: rtl/fwio_wb_engine.sv
module fwio_wb_engine #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          we_i,
  input  logic [AW-1:0] adr_i,
  input  logic [DW-1:0] dat_i,
  output logic          ready_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          wb_cyc_o,
  output logic          wb_stb_o,
  output logic          wb_we_o,
  output logic [AW-1:0] wb_adr_o,
  output logic [DW-1:0] wb_dat_o,
  input  logic [DW-1:0] wb_dat_i,
  input  logic          wb_ack_i
);
  logic          cyc_q, cyc_d;
  logic          done_q, done_d;
  logic          load_en, cap_en;
  logic          we_q;
  logic [AW-1:0] adr_q;
  logic [DW-1:0] dat_q;
  logic [DW-1:0] rdata_q;

  // next-state
  always_comb begin
    load_en = start_i & ~cyc_q;
    cap_en  = cyc_q & wb_ack_i;
    cyc_d   = cyc_q;
    if (load_en)     cyc_d = 1'b1;
    else if (cap_en) cyc_d = 1'b0;
    done_d  = cap_en;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cyc_q  <= cyc_d;
      done_q <= done_d;
    end
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk) begin
    if (load_en) begin
      we_q  <= we_i;
      adr_q <= adr_i;
      dat_q <= dat_i;
    end
    if (cap_en) rdata_q <= wb_dat_i;
  end

  assign ready_o  = ~cyc_q;
  assign done_o   = done_q;
  assign rdata_o  = rdata_q;
  assign wb_cyc_o = cyc_q;
  assign wb_stb_o = cyc_q;
  assign wb_we_o  = we_q;
  assign wb_adr_o = adr_q;
  assign wb_dat_o = dat_q;
endmodule

// File: rtl/fwio_wb_master.sv
module fwio_wb_master
  import fwio_wb_pkg::*;
#(
  parameter int IO_AW = 16,
  parameter int IO_DW = 8,
  parameter int FW_AW = 28,
  parameter int FW_DW = 32,
  localparam int FW_SW  = FW_DW / 8,
  localparam int FW_OW  = $clog2(FW_SW),
  localparam int FW_WAW = FW_AW - FW_OW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_fw,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [FW_AW-1:0]  req_addr,
  input  logic [FW_DW-1:0]  req_wdata,
  output logic              io_ready,
  output logic              fw_ready,
  output logic              io_done,
  output logic [IO_DW-1:0]  io_rdata,
  output logic              fw_done,
  output logic [FW_DW-1:0]  fw_rdata,
  output logic              io_wb_cyc,
  output logic              io_wb_stb,
  output logic              io_wb_we,
  output logic [IO_AW-1:0]  io_wb_adr,
  output logic [IO_DW-1:0]  io_wb_dat_w,
  input  logic [IO_DW-1:0]  io_wb_dat_r,
  input  logic              io_wb_ack,
  output logic              fw_wb_cyc,
  output logic              fw_wb_stb,
  output logic              fw_wb_we,
  output logic [FW_WAW-1:0] fw_wb_adr,
  output logic [FW_SW-1:0]  fw_wb_sel,
  output logic [FW_DW-1:0]  fw_wb_dat_w,
  input  logic [FW_DW-1:0]  fw_wb_dat_r,
  input  logic              fw_wb_ack
);
  logic rst_n_s;
  logic io_start, fw_start;

  fwio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign io_start = req_valid & ~req_fw & io_ready;
  assign fw_start = req_valid &  req_fw & fw_ready;

  // I/O port: address and data pass through unchanged
  fwio_wb_engine #(.AW(IO_AW), .DW(IO_DW)) u_io (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start_i  (io_start),
    .we_i     (req_write),
    .adr_i    (req_addr[IO_AW-1:0]),
    .dat_i    (req_wdata[IO_DW-1:0]),
    .ready_o  (io_ready),
    .done_o   (io_done),
    .rdata_o  (io_rdata),
    .wb_cyc_o (io_wb_cyc),
    .wb_stb_o (io_wb_stb),
    .wb_we_o  (io_wb_we),
    .wb_adr_o (io_wb_adr),
    .wb_dat_o (io_wb_dat_w),
    .wb_dat_i (io_wb_dat_r),
    .wb_ack_i (io_wb_ack)
  );

  // firmware port: lane planning on the incoming request
  logic [FW_SW-1:0] plan_sel;
  logic [FW_OW-1:0] plan_off;
  logic [FW_DW-1:0] plan_mask, plan_lanes;

  fwio_lane_plan #(.DW(FW_DW)) u_plan (
    .size_i    (xfer_size_e'(req_size)),
    .addr_lo_i (req_addr[FW_OW-1:0]),
    .wdata_i   (req_wdata),
    .sel_o     (plan_sel),
    .off_o     (plan_off),
    .mask_o    (plan_mask),
    .lanes_o   (plan_lanes)
  );

  logic [FW_DW-1:0] fw_raw;

  fwio_wb_engine #(.AW(FW_WAW), .DW(FW_DW)) u_fw (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start_i  (fw_start),
    .we_i     (req_write),
    .adr_i    (req_addr[FW_AW-1:FW_OW]),
    .dat_i    (plan_lanes),
    .ready_o  (fw_ready),
    .done_o   (fw_done),
    .rdata_o  (fw_raw),
    .wb_cyc_o (fw_wb_cyc),
    .wb_stb_o (fw_wb_stb),
    .wb_we_o  (fw_wb_we),
    .wb_adr_o (fw_wb_adr),
    .wb_dat_o (fw_wb_dat_w),
    .wb_dat_i (fw_wb_dat_r),
    .wb_ack_i (fw_wb_ack)
  );

  // lane plan kept for the whole cycle, reused for read alignment
  logic [FW_SW-1:0] sel_q;
  logic [FW_OW-1:0] off_q;
  logic [FW_DW-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (fw_start) begin
      sel_q  <= plan_sel;
      off_q  <= plan_off;
      mask_q <= plan_mask;
    end
  end

  assign fw_wb_sel = sel_q;
  assign fw_rdata  = (fw_raw >> {off_q, 3'b000}) & mask_q;
endmodule

// File: rtl/fwio_wb_master_chk.sv
module fwio_wb_master_chk #(
  parameter int IO_AW  = 16,
  parameter int IO_DW  = 8,
  parameter int FW_DW  = 32,
  parameter int FW_WAW = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_ready,
  input logic              io_done,
  input logic              fw_done,
  input logic              io_wb_cyc,
  input logic              io_wb_we,
  input logic [IO_AW-1:0]  io_wb_adr,
  input logic [IO_DW-1:0]  io_wb_dat_w,
  input logic              io_wb_ack,
  input logic              fw_wb_cyc,
  input logic              fw_wb_we,
  input logic [FW_WAW-1:0] fw_wb_adr,
  input logic [FW_DW/8-1:0] fw_wb_sel,
  input logic [FW_DW-1:0]  fw_wb_dat_w,
  input logic              fw_wb_ack
);
  // R3
  io_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_wb_cyc && !io_wb_ack |=> io_wb_cyc && $stable(io_wb_adr)
                                && $stable(io_wb_we) && $stable(io_wb_dat_w));

  // R3
  fw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fw_wb_cyc && !fw_wb_ack |=> fw_wb_cyc && $stable(fw_wb_adr) && $stable(fw_wb_sel)
                                && $stable(fw_wb_we) && $stable(fw_wb_dat_w));

  // R3
  fw_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fw_wb_cyc && fw_wb_ack |=> !fw_wb_cyc);

  // R4
  io_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_wb_cyc && io_wb_ack |=> io_done);

  // R4
  fw_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fw_done |=> !fw_done);

  // R5
  io_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_wb_cyc |-> !io_ready);

  // R7 R8 R9
  fw_sel_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fw_wb_cyc |-> (fw_wb_sel inside {4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                     4'b0011, 4'b1100, 4'b1111}));
endmodule

bind fwio_wb_master fwio_wb_master_chk #(
  .IO_AW(IO_AW), .IO_DW(IO_DW), .FW_DW(FW_DW), .FW_WAW(FW_WAW)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .io_ready    (io_ready),
  .io_done     (io_done),
  .fw_done     (fw_done),
  .io_wb_cyc   (io_wb_cyc),
  .io_wb_we    (io_wb_we),
  .io_wb_adr   (io_wb_adr),
  .io_wb_dat_w (io_wb_dat_w),
  .io_wb_ack   (io_wb_ack),
  .fw_wb_cyc   (fw_wb_cyc),
  .fw_wb_we    (fw_wb_we),
  .fw_wb_adr   (fw_wb_adr),
  .fw_wb_sel   (fw_wb_sel),
  .fw_wb_dat_w (fw_wb_dat_w),
  .fw_wb_ack   (fw_wb_ack)
);

// File: tb/fwio_wb_master_tb.sv
module fwio_wb_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_fw, req_write;
  logic [1:0]  req_size;
  logic [27:0] req_addr;
  logic [31:0] req_wdata;
  logic        io_ready, fw_ready, io_done, fw_done;
  logic [7:0]  io_rdata;
  logic [31:0] fw_rdata;
  logic        io_wb_cyc, io_wb_stb, io_wb_we, io_wb_ack;
  logic [15:0] io_wb_adr;
  logic [7:0]  io_wb_dat_w, io_wb_dat_r;
  logic        fw_wb_cyc, fw_wb_stb, fw_wb_we, fw_wb_ack;
  logic [25:0] fw_wb_adr;
  logic [3:0]  fw_wb_sel;
  logic [31:0] fw_wb_dat_w, fw_wb_dat_r;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  fwio_wb_master dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_fw(req_fw), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .io_ready(io_ready), .fw_ready(fw_ready),
    .io_done(io_done), .io_rdata(io_rdata),
    .fw_done(fw_done), .fw_rdata(fw_rdata),
    .io_wb_cyc(io_wb_cyc), .io_wb_stb(io_wb_stb), .io_wb_we(io_wb_we),
    .io_wb_adr(io_wb_adr), .io_wb_dat_w(io_wb_dat_w),
    .io_wb_dat_r(io_wb_dat_r), .io_wb_ack(io_wb_ack),
    .fw_wb_cyc(fw_wb_cyc), .fw_wb_stb(fw_wb_stb), .fw_wb_we(fw_wb_we),
    .fw_wb_adr(fw_wb_adr), .fw_wb_sel(fw_wb_sel), .fw_wb_dat_w(fw_wb_dat_w),
    .fw_wb_dat_r(fw_wb_dat_r), .fw_wb_ack(fw_wb_ack)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected lane offset, mask and selects from R7..R9
  function automatic logic [1:0] e_off(input logic [1:0] sz, input logic [27:0] a);
    if (sz == 2'b00)      return a[1:0];
    else if (sz == 2'b01) return {a[1], 1'b0};
    else                  return 2'b00;
  endfunction
  function automatic logic [31:0] e_mask(input logic [1:0] sz);
    if (sz == 2'b00)      return 32'h0000_00FF;
    else if (sz == 2'b01) return 32'h0000_FFFF;
    else                  return 32'hFFFF_FFFF;
  endfunction
  function automatic logic [3:0] e_sel(input logic [1:0] sz, input logic [27:0] a);
    if (sz == 2'b00)      return 4'b0001 << e_off(sz, a);
    else if (sz == 2'b01) return 4'b0011 << e_off(sz, a);
    else                  return 4'b1111;
  endfunction

  // drive one request for one edge, return at the following negedge
  task automatic issue(input bit fw, input bit wr, input logic [1:0] sz,
                       input logic [27:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_fw = fw; req_write = wr;
    req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 io_ready", 32'(io_ready), 32'd1);
    chk("R1 fw_ready", 32'(fw_ready), 32'd1);
    chk("R1 cyc", {30'd0, io_wb_cyc, fw_wb_cyc}, 32'd0);
    chk("R1 stb", {30'd0, io_wb_stb, fw_wb_stb}, 32'd0);
    chk("R1 done", {30'd0, io_done, fw_done}, 32'd0);
  endtask

  task automatic t_io_write_slow();
    issue(1'b0, 1'b1, 2'b00, 28'hABC_03F8, 32'h1234_56A5);
    chk("R2 io cyc/stb", {30'd0, io_wb_cyc, io_wb_stb}, 32'd3);
    chk("R2 io adr", 32'(io_wb_adr), 32'h03F8);
    chk("R2 io we", 32'(io_wb_we), 32'd1);
    chk("R2 io dat_w", 32'(io_wb_dat_w), 32'hA5);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 io held cyc", 32'(io_wb_cyc), 32'd1);
      chk("R3 io held adr", 32'(io_wb_adr), 32'h03F8);
      chk("R4 no early done", 32'(io_done), 32'd0);
    end
    io_wb_ack = 1'b1;
    @(negedge clk);
    io_wb_ack = 1'b0;
    chk("R3 io released", {30'd0, io_wb_cyc, io_wb_stb}, 32'd0);
    chk("R4 io done", 32'(io_done), 32'd1);
    @(negedge clk);
    chk("R4 io done one cycle", 32'(io_done), 32'd0);
  endtask

  task automatic t_io_read();
    issue(1'b0, 1'b0, 2'b00, 28'h000_0080, 32'h0);
    chk("R2 io we read", 32'(io_wb_we), 32'd0);
    chk("R2 io adr read", 32'(io_wb_adr), 32'h0080);
    io_wb_ack = 1'b1; io_wb_dat_r = 8'h5C;
    @(negedge clk);
    io_wb_ack = 1'b0; io_wb_dat_r = 8'h00;
    chk("R4 io done read", 32'(io_done), 32'd1);
    chk("R4 io rdata", 32'(io_rdata), 32'h5C);
  endtask

  task automatic t_io_busy();
    issue(1'b0, 1'b0, 2'b00, 28'h000_1111, 32'h0);
    chk("R5 io not ready", 32'(io_ready), 32'd0);
    req_valid = 1'b1; req_fw = 1'b0; req_write = 1'b1; req_addr = 28'h000_2222;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R5 busy request ignored adr", 32'(io_wb_adr), 32'h1111);
    chk("R5 busy request ignored we", 32'(io_wb_we), 32'd0);
    io_wb_ack = 1'b1;
    @(negedge clk);
    io_wb_ack = 1'b0;
    chk("R5 ready in done cycle", 32'(io_ready), 32'd1);
    @(negedge clk);
    chk("R5 no second cycle", 32'(io_wb_cyc), 32'd0);
  endtask

  task automatic fw_case(input bit wr, input logic [1:0] sz, input logic [27:0] a,
                         input logic [31:0] d, input string tag);
    logic [1:0]  off;
    logic [31:0] resp;
    off  = e_off(sz, a);
    resp = 32'hC3B2_A190;
    issue(1'b1, wr, sz, a, d);
    chk({"R6 fw adr ", tag}, 32'(fw_wb_adr), 32'(a >> 2));
    chk({"R6 fw we ", tag}, 32'(fw_wb_we), 32'(wr));
    chk({tag, " sel"}, 32'(fw_wb_sel), 32'(e_sel(sz, a)));
    if (wr) chk({tag, " dat_w"}, fw_wb_dat_w, (d & e_mask(sz)) << (8 * off));
    fw_wb_ack = 1'b1; fw_wb_dat_r = resp;
    @(negedge clk);
    fw_wb_ack = 1'b0; fw_wb_dat_r = 32'h0;
    chk({"R4 fw done ", tag}, 32'(fw_done), 32'd1);
    chk({"R3 fw released ", tag}, 32'(fw_wb_cyc), 32'd0);
    if (!wr) chk({"R10 fw rdata ", tag}, fw_rdata, (resp >> (8 * off)) & e_mask(sz));
  endtask

  task automatic t_fw_sweep(input bit wr);
    fw_case(wr, 2'b00, 28'h123_4560, 32'h0000_00E1, "R7 b0");
    fw_case(wr, 2'b00, 28'h123_4561, 32'hFFFF_FFE2, "R7 b1");
    fw_case(wr, 2'b00, 28'h123_4562, 32'h0000_55E3, "R7 b2");
    fw_case(wr, 2'b00, 28'h123_4563, 32'h0000_00E4, "R7 b3");
    fw_case(wr, 2'b01, 28'h0FE_DCB0, 32'hAAAA_BEEF, "R8 h0");
    fw_case(wr, 2'b01, 28'h0FE_DCB2, 32'h0000_CAFE, "R8 h2");
    fw_case(wr, 2'b01, 28'h0FE_DCB3, 32'h1111_F00D, "R8 h3 bit0 ignored");
    fw_case(wr, 2'b10, 28'h765_4320, 32'h8765_4321, "R9 w0");
    fw_case(wr, 2'b11, 28'h765_4323, 32'h0BAD_F00D, "R9 w3 low ignored");
  endtask

  task automatic t_overlap();
    issue(1'b0, 1'b1, 2'b00, 28'h000_0060, 32'h77);
    issue(1'b1, 1'b0, 2'b10, 28'h000_0100, 32'h0);
    chk("R11 both open", {30'd0, io_wb_cyc, fw_wb_cyc}, 32'd3);
    fw_wb_ack = 1'b1; fw_wb_dat_r = 32'h0102_0304;
    @(negedge clk);
    fw_wb_ack = 1'b0;
    chk("R11 fw done alone", {30'd0, fw_done, io_done}, 32'd2);
    chk("R11 io still open", 32'(io_wb_cyc), 32'd1);
    chk("R11 fw rdata", fw_rdata, 32'h0102_0304);
    io_wb_ack = 1'b1;
    @(negedge clk);
    io_wb_ack = 1'b0;
    chk("R11 io done", 32'(io_done), 32'd1);
    chk("R11 io closed", 32'(io_wb_cyc), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_fw = 1'b0; req_write = 1'b0;
    req_size = 2'b00; req_addr = '0; req_wdata = '0;
    io_wb_ack = 1'b0; io_wb_dat_r = '0;
    fw_wb_ack = 1'b0; fw_wb_dat_r = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_io_write_slow();
    t_io_read();
    t_io_busy();
    t_fw_sweep(1'b1);
    t_fw_sweep(1'b0);
    t_overlap();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule